// File: doc/BRIEF.md
# Precise Pipeline Trap Controller

This block sits beside a five-stage in-order pipeline (fetch, decode, execute, data memory, write-back) and decides when the pipeline leaves normal flow for the exception handler. Each cycle it looks at the fault flags raised by the stages: a fetch from an address with no memory behind it, an undefined opcode or a system-call request in decode, arithmetic overflow in execute, and a store to an illegal address in the memory stage. It also watches an external interrupt line. When more than one stage complains in the same cycle, it services the instruction that is furthest down the pipe. The younger requests are dropped, since those instructions are fetched again after the handler returns.

On taking a trap, in that same cycle the block redirects the PC to a fixed handler address. It also kills the faulting instruction and everything younger. The fetch slot becomes a bubble, and the decode, execute and memory slots have their write-enabling controls cleared. Instructions older than the faulting one finish normally. On the next clock edge it records the faulting instruction's PC and a cause code. It then ignores every further request until the handler issues a return strobe, which sends the PC back to the recorded address.

Top module: `pipe_trap_ctrl`

## Requirements
- R1: After reset, `redirect`, all four kill outputs and `in_trap` are 0, and `epc` and `cause` are 0.
- R2: Among simultaneous requests, priority from high to low is `dm_fault`, `ex_ovf`, `id_illegal`, `id_syscall`, `if_fault`, `irq`. Only the highest one present is serviced.
- R3: When a trap is taken, the kill outputs are asserted in the same cycle for the faulting stage and every younger stage, and for no older stage. Faulting stages map as follows: memory kills {dm,ex,id,if}, execute kills {ex,id,if}, decode kills {id,if}, fetch kills {if}.
- R4: A memory-stage fault asserts `kill_dm`, which suppresses that instruction's register and memory writes. `kill_dm` is never asserted for any other source.
- R5: `irq` is taken only when no internal fault flag is set in that cycle. It is attributed to the decode instruction: cause 0, saved PC `id_pc`, kills {id,if}.
- R6: A trap raises `redirect` with `redirect_pc` equal to `HANDLER_PC` (default 32'h8000_0180) combinationally, for exactly that one cycle.
- R7: On the clock edge that takes a trap, `epc` loads the faulting stage's PC and `cause` loads its code: 0 external interrupt, 1 fetch address fault, 2 undefined opcode, 3 overflow, 4 store address fault, 5 system call.
- R8: From that edge until a return, `in_trap` is 1. All fault and interrupt inputs are ignored: no redirect, no kills, and `epc`/`cause` unchanged.
- R9: `eret` while `in_trap` is 1 drives `redirect` with `redirect_pc` equal to `epc` in that cycle and clears `in_trap` on the next edge. `eret` while `in_trap` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_fault | input | 1 | Fetch from nonexistent address |
| id_illegal | input | 1 | Undefined opcode in decode |
| id_syscall | input | 1 | System-call request in decode |
| ex_ovf | input | 1 | Arithmetic overflow in execute |
| dm_fault | input | 1 | Store to illegal address in memory stage |
| irq | input | 1 | External interrupt request |
| eret | input | 1 | Return-from-handler strobe |
| if_pc | input | XLEN | PC of fetch-stage instruction |
| id_pc | input | XLEN | PC of decode-stage instruction |
| ex_pc | input | XLEN | PC of execute-stage instruction |
| dm_pc | input | XLEN | PC of memory-stage instruction |
| redirect | output | 1 | Load PC from `redirect_pc` this cycle |
| redirect_pc | output | XLEN | Handler address or saved PC |
| kill_if | output | 1 | Turn fetched instruction into a bubble |
| kill_id | output | 1 | Clear write controls in decode |
| kill_ex | output | 1 | Clear write controls in execute |
| kill_dm | output | 1 | Clear write controls in memory stage |
| epc | output | XLEN | Saved PC of the trapping instruction |
| cause | output | 3 | Saved cause code |
| in_trap | output | 1 | Handler active; requests masked |

## Verification
The hardest cases to reach are the ones where several stages fault at once, and the ones where requests arrive while the handler is active. In both, the right answer is that something did not happen. The bench applies all 64 combinations of the six request inputs from the idle state, with a distinct PC in each stage, so each stage's PC identifies which request won. After each trap, it holds every request high while `in_trap` is set and checks that nothing moved. It then returns and checks that the PC restored is the one saved.

// File: rtl/pipe_trap_ctrl.sv
module pipe_trap_ctrl #(
  parameter int              XLEN       = 32,
  parameter logic [XLEN-1:0] HANDLER_PC = 32'h8000_0180
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            if_fault,
  input  logic            id_illegal,
  input  logic            id_syscall,
  input  logic            ex_ovf,
  input  logic            dm_fault,
  input  logic            irq,
  input  logic            eret,
  input  logic [XLEN-1:0] if_pc,
  input  logic [XLEN-1:0] id_pc,
  input  logic [XLEN-1:0] ex_pc,
  input  logic [XLEN-1:0] dm_pc,
  output logic            redirect,
  output logic [XLEN-1:0] redirect_pc,
  output logic            kill_if,
  output logic            kill_id,
  output logic            kill_ex,
  output logic            kill_dm,
  output logic [XLEN-1:0] epc,
  output logic [2:0]      cause,
  output logic            in_trap
);

  logic            any_req;
  logic [2:0]      sel_cause;
  logic [XLEN-1:0] sel_pc;
  logic [3:0]      sel_kill;

  always_comb begin
    any_req   = 1'b1;
    sel_cause = 3'd0;
    sel_pc    = id_pc;
    sel_kill  = 4'b0000;
    if (dm_fault) begin
      sel_cause = 3'd4; sel_pc = dm_pc; sel_kill = 4'b1111;
    end else if (ex_ovf) begin
      sel_cause = 3'd3; sel_pc = ex_pc; sel_kill = 4'b0111;
    end else if (id_illegal) begin
      sel_cause = 3'd2; sel_pc = id_pc; sel_kill = 4'b0011;
    end else if (id_syscall) begin
      sel_cause = 3'd5; sel_pc = id_pc; sel_kill = 4'b0011;
    end else if (if_fault) begin
      sel_cause = 3'd1; sel_pc = if_pc; sel_kill = 4'b0001;
    end else if (irq) begin
      sel_cause = 3'd0; sel_pc = id_pc; sel_kill = 4'b0011;
    end else begin
      any_req = 1'b0;
    end
  end

  wire take = ~in_trap & any_req;
  wire ret  = in_trap & eret;

  assign {kill_dm, kill_ex, kill_id, kill_if} = {4{take}} & sel_kill;
  assign redirect    = take | ret;
  assign redirect_pc = ret ? epc : HANDLER_PC;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_trap <= 1'b0;
      epc     <= '0;
      cause   <= '0;
    end else if (take) begin
      in_trap <= 1'b1;
      epc     <= sel_pc;
      cause   <= sel_cause;
    end else if (ret) begin
      in_trap <= 1'b0;
    end
  end

  AST_KILL_DM_NEST: assert property (@(posedge clk) disable iff (!rst_n) kill_dm |-> kill_ex) else $error("kill nesting"); // R3
  AST_KILL_EX_NEST: assert property (@(posedge clk) disable iff (!rst_n) kill_ex |-> kill_id) else $error("kill nesting"); // R3
  AST_KILL_ID_NEST: assert property (@(posedge clk) disable iff (!rst_n) kill_id |-> kill_if) else $error("kill nesting"); // R3
  AST_KILL_DM_SRC:  assert property (@(posedge clk) disable iff (!rst_n) kill_dm |-> dm_fault) else $error("kill_dm source"); // R4
  AST_ONE_CYCLE:    assert property (@(posedge clk) disable iff (!rst_n) (redirect && !in_trap) |=> (!redirect || eret)) else $error("redirect length"); // R6
  AST_TAKE_MASKS:   assert property (@(posedge clk) disable iff (!rst_n) (kill_if && !in_trap) |=> in_trap) else $error("mask not set"); // R8
  AST_MASK_QUIET:   assert property (@(posedge clk) disable iff (!rst_n) in_trap |-> !kill_if) else $error("kill while masked"); // R8
  AST_EPC_HOLD:     assert property (@(posedge clk) disable iff (!rst_n) in_trap |=> ($stable(epc) && $stable(cause))) else $error("epc moved"); // R8
  AST_CAUSE_RANGE:  assert property (@(posedge clk) disable iff (!rst_n) cause <= 3'd5) else $error("bad cause"); // R7
  AST_RET_CLEARS:   assert property (@(posedge clk) disable iff (!rst_n) (in_trap && eret) |=> !in_trap) else $error("return"); // R9

endmodule

// File: tb/test_pipe_trap_ctrl.sv
module test_pipe_trap_ctrl;
  localparam int XLEN = 32;
  localparam logic [XLEN-1:0] HND = 32'h8000_0180;

  logic clk = 1'b0, rst_n = 1'b0;
  logic if_fault = 0, id_illegal = 0, id_syscall = 0, ex_ovf = 0, dm_fault = 0, irq = 0, eret = 0;
  logic [XLEN-1:0] if_pc = 0, id_pc = 0, ex_pc = 0, dm_pc = 0;
  logic redirect, kill_if, kill_id, kill_ex, kill_dm, in_trap;
  logic [XLEN-1:0] redirect_pc, epc;
  logic [2:0] cause;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  pipe_trap_ctrl #(.XLEN(XLEN), .HANDLER_PC(HND)) i_pipe_trap_ctrl (
    .clk, .rst_n, .if_fault, .id_illegal, .id_syscall, .ex_ovf, .dm_fault, .irq, .eret,
    .if_pc, .id_pc, .ex_pc, .dm_pc, .redirect, .redirect_pc, .kill_if, .kill_id,
    .kill_ex, .kill_dm, .epc, .cause, .in_trap);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [5:0] v, input logic r);
    {irq, dm_fault, ex_ovf, id_syscall, id_illegal, if_fault} = v;
    eret = r;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 redirect", redirect, 0);
    chk("R1 kills", {kill_dm, kill_ex, kill_id, kill_if}, 0);
    chk("R1 in_trap", in_trap, 0);
    chk("R1 epc", epc, 0);
    chk("R1 cause", cause, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int v = 0; v < 64; v++) begin
      logic [2:0] ec;
      logic [XLEN-1:0] ep;
      logic [3:0] ek;
      logic taken;
      @(negedge clk);
      if_pc = 32'h1000 + v * 16; id_pc = if_pc - 4; ex_pc = if_pc - 8; dm_pc = if_pc - 12;
      taken = 1'b1;
      if (v[4])      begin ec = 4; ep = dm_pc; ek = 4'b1111; end // R2 R4 memory oldest
      else if (v[3]) begin ec = 3; ep = ex_pc; ek = 4'b0111; end
      else if (v[1]) begin ec = 2; ep = id_pc; ek = 4'b0011; end
      else if (v[2]) begin ec = 5; ep = id_pc; ek = 4'b0011; end
      else if (v[0]) begin ec = 1; ep = if_pc; ek = 4'b0001; end
      else if (v[5]) begin ec = 0; ep = id_pc; ek = 4'b0011; end // R5
      else begin ec = 0; ep = 0; ek = 0; taken = 1'b0; end
      drive(v[5:0], 1'b0);
      #1;
      chk("R6 redirect", redirect, taken);
      if (taken) chk("R6 handler pc", redirect_pc, HND);
      chk("R3 kills", {kill_dm, kill_ex, kill_id, kill_if}, ek);
      chk("R4 kill_dm", kill_dm, v[4]);
      @(negedge clk);
      drive(6'd0, 1'b0);
      #1;
      chk("R8 in_trap", in_trap, taken);
      if (!taken) begin
        drive(6'd0, 1'b1);
        #1;
        chk("R9 eret ignored", redirect, 0);
        @(negedge clk);
        drive(6'd0, 1'b0);
        #1;
        chk("R9 still idle", in_trap, 0);
        continue;
      end
      chk("R7 epc", epc, ep);
      chk("R7 cause", cause, ec);
      chk("R6 one cycle", redirect, 0);
      drive(6'h3f, 1'b0);
      #1;
      chk("R8 masked redirect", redirect, 0);
      chk("R8 masked kills", {kill_dm, kill_ex, kill_id, kill_if}, 0);
      @(negedge clk);
      #1;
      chk("R8 epc held", epc, ep);
      chk("R8 cause held", cause, ec);
      drive(6'd0, 1'b1);
      #1;
      chk("R9 return redirect", redirect, 1);
      chk("R9 return pc", redirect_pc, ep);
      @(negedge clk);
      drive(6'd0, 1'b0);
      #1;
      chk("R9 in_trap cleared", in_trap, 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule